// File: doc/BRIEF.md
# Staged-jump program counter

This block holds the 16-bit instruction address of a processor whose data bus carries one byte per move. A jump cannot place a full address on the bus in one transfer, so it is split in two. A move to the page destination puts a byte into a holding register and leaves the running address alone. A later move to the offset destination loads the whole address in one edge: the held byte becomes the upper half and the moved byte the lower half. Every jump is therefore absolute. The held page stays after the jump, so a second jump inside the same page needs only the offset move.

Each instruction lasts a fixed number of clock cycles, two by default. The block runs its own step sequence and flags the last cycle of each instruction. Destination writes are taken only in that cycle. When an instruction ends without an offset write, the address advances by one. The address output feeds the source and destination instruction memories, and it stays constant for the whole of an instruction.

Top module: `jump_pc`

## Requirements
- R1: While `rst_n` is low at a rising edge, the address, the held page and the step count all go to zero. `instr_last` is low in the first cycle after reset, and the held page reads as 0x00 on the next jump.
- R2: An instruction lasts exactly two cycles. `instr_last` is low in the first cycle and high in the second, and the pattern repeats without a gap.
- R3: An instruction that ends without an offset write adds one to `instr_addr`, and 0xFFFF wraps to 0x0000. The new value appears in the first cycle of the next instruction.
- R4: A write to destination 0x02 in the last cycle puts `wr_data` into the held page, and the address still advances by one.
- R5: A write to destination 0x01 in the last cycle sets `instr_addr` to {held page, `wr_data`} in place of the increment. The new value appears in the first cycle of the next instruction.
- R6: The held page keeps its value through jumps and increments. Later offset writes with no page write in between all land in the same page.
- R7: A write has no effect on the address or the held page if it goes to any destination other than 0x01 or 0x02, if `wr_en` is low, or if it comes in a cycle that is not the last of an instruction.
- R8: `instr_addr` does not change between the first and the last cycle of an instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every register updates on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | A bus move writes a destination in this cycle |
| wr_dest | input | 8 | Destination address of the move |
| wr_data | input | 8 | Byte being moved |
| instr_addr | output | 16 | Address of the instruction now executing |
| instr_last | output | 1 | High in the last cycle of an instruction |

## Verification
A write presented in the last cycle of an instruction is taken at the edge that ends it. Its effect on `instr_addr` is due in the following cycle, which is the first cycle of the next instruction. A write to the held page cannot be seen directly, so it is checked through the next offset jump. The bench drives every input at a falling edge and steps through instructions one cycle at a time. It reads `instr_addr` and `instr_last` at the falling edge of both cycles of every instruction, before it drives anything new. The new address is therefore compared exactly one cycle after the write, and its stability across the instruction is confirmed at the second sample.

// File: rtl/jpc_pkg.sv
// Shared definitions for the staged-jump program counter.
// Assumes: nothing beyond the standard language.
package jpc_pkg;

    // Effect of a bus move on the program counter, as classified by the decoder
    typedef enum logic [1:0] {
        WK_NONE = 2'd0,   // move does not concern the counter
        WK_PAGE = 2'd1,   // move loads the held upper byte
        WK_OFFS = 2'd2    // move loads the lower byte and triggers the jump
    } wr_kind_e;

endpackage

// File: rtl/jpc_step_seq.sv
// Step sequencer: counts the cycles of each fixed-length instruction and
// flags its last cycle.
// Assumes: STEPS >= 2; synchronous active-low reset puts the sequence at step 0.
module jpc_step_seq #(
    parameter int STEPS = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic last
);
    localparam int SW = (STEPS > 2) ? $clog2(STEPS) : 1;

    generate
        if (STEPS == 2) begin : g_toggle
            logic tog_q;

            // Two-step instructions: one flop alternates first and last cycle
            always_ff @(posedge clk) begin
                if (!rst_n) tog_q <= 1'b0;
                else        tog_q <= ~tog_q;
            end

            assign last = tog_q;
        end else begin : g_count
            logic [SW-1:0] step_q;

            // Longer instructions: a counter wraps after its last step
            always_ff @(posedge clk) begin
                if (!rst_n)                       step_q <= '0;
                else if (step_q == SW'(STEPS-1))  step_q <= '0;
                else                              step_q <= step_q + SW'(1);
            end

            assign last = (step_q == SW'(STEPS-1));
        end
    endgenerate

    // R2
    last_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        last |=> !last);

endmodule

// File: rtl/jpc_dest_decode.sv
// Destination decoder: sorts a bus move into page load, offset load or
// nothing. A move counts only in the last cycle of an instruction.
// Assumes: PAGE_DEST differs from OFFS_DEST.
module jpc_dest_decode
    import jpc_pkg::*;
#(
    parameter int              DATA_W    = 8,
    parameter logic [DATA_W-1:0] PAGE_DEST = 8'h02,
    parameter logic [DATA_W-1:0] OFFS_DEST = 8'h01
) (
    input  logic              wr_en,
    input  logic              last,
    input  logic [DATA_W-1:0] wr_dest,
    output wr_kind_e          kind
);
    // Classify the move; anything outside the write cycle is ignored
    always_comb begin
        kind = WK_NONE;
        if (wr_en && last) begin
            if (wr_dest == OFFS_DEST)      kind = WK_OFFS;
            else if (wr_dest == PAGE_DEST) kind = WK_PAGE;
        end
    end

    // R7
    kind_gate_chk: assert final (!(kind != WK_NONE && !(wr_en && last)));

endmodule

// File: rtl/jpc_page_reg.sv
// Page holding register: keeps the upper address byte for the next jump.
// Assumes: it is loaded only by a classified page move; it is never cleared
// by a jump.
module jpc_page_reg
    import jpc_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  wr_kind_e          kind,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] page
);
    // Capture the byte on a page move, otherwise keep the held value
    always_ff @(posedge clk) begin
        if (!rst_n)              page <= '0;
        else if (kind == WK_PAGE) page <= wr_data;
    end

endmodule

// File: rtl/jpc_addr_reg.sv
// Address register: at the end of each instruction it either jumps to
// {page, offset} or steps to the next address.
// Assumes: 'advance' is high for exactly one cycle per instruction.
module jpc_addr_reg
    import jpc_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                advance,
    input  wr_kind_e            kind,
    input  logic [DATA_W-1:0]   page,
    input  logic [DATA_W-1:0]   wr_data,
    output logic [2*DATA_W-1:0] addr
);
    localparam int ADDR_W = 2 * DATA_W;

    logic [ADDR_W-1:0] next_addr;

    // Choose the jump target over the increment when an offset move arrives
    always_comb begin
        if (kind == WK_OFFS) next_addr = {page, wr_data};
        else                 next_addr = addr + ADDR_W'(1);
    end

    // Update the address once per instruction, in its last cycle
    always_ff @(posedge clk) begin
        if (!rst_n)       addr <= '0;
        else if (advance) addr <= next_addr;
    end

endmodule

// File: rtl/jump_pc.sv
// Staged-jump program counter: a 2*DATA_W-bit instruction address loaded in
// two byte-wide moves (page first, offset second), or else incremented at
// the end of each fixed-length instruction.
// Assumes: moves are presented in the last cycle of an instruction;
// synchronous active-low reset.
module jump_pc
    import jpc_pkg::*;
#(
    parameter int                DATA_W    = 8,
    parameter int                STEPS     = 2,
    parameter logic [DATA_W-1:0] PAGE_DEST = 8'h02,
    parameter logic [DATA_W-1:0] OFFS_DEST = 8'h01
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [DATA_W-1:0]   wr_dest,
    input  logic [DATA_W-1:0]   wr_data,
    output logic [2*DATA_W-1:0] instr_addr,
    output logic                instr_last
);
    localparam int ADDR_W = 2 * DATA_W;

    logic              last;
    wr_kind_e          kind;
    logic [DATA_W-1:0] page_q;

    jpc_step_seq #(.STEPS(STEPS)) u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .last  (last)
    );

    jpc_dest_decode #(
        .DATA_W    (DATA_W),
        .PAGE_DEST (PAGE_DEST),
        .OFFS_DEST (OFFS_DEST)
    ) u_dec (
        .wr_en   (wr_en),
        .last    (last),
        .wr_dest (wr_dest),
        .kind    (kind)
    );

    jpc_page_reg #(.DATA_W(DATA_W)) u_page (
        .clk     (clk),
        .rst_n   (rst_n),
        .kind    (kind),
        .wr_data (wr_data),
        .page    (page_q)
    );

    jpc_addr_reg #(.DATA_W(DATA_W)) u_addr (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (last),
        .kind    (kind),
        .page    (page_q),
        .wr_data (wr_data),
        .addr    (instr_addr)
    );

    assign instr_last = last;

    // R8
    addr_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_last |=> $stable(instr_addr));

    // R3
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_last && !(wr_en && wr_dest == OFFS_DEST))
        |=> instr_addr == $past(instr_addr) + ADDR_W'(1));

    // R5
    addr_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_last && wr_en && wr_dest == OFFS_DEST)
        |=> instr_addr == {$past(page_q), $past(wr_data)});

    // R4
    page_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_last && wr_en && wr_dest == PAGE_DEST)
        |=> page_q == $past(wr_data));

    // R6
    page_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(instr_last && wr_en && wr_dest == PAGE_DEST) |=> $stable(page_q));

endmodule

// File: tb/jump_pc_tb.sv
`timescale 1ns/1ps
module jump_pc_tb;
    localparam logic [7:0] PAGE_D = 8'h02;
    localparam logic [7:0] OFFS_D = 8'h01;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_dest = 8'h00;
    logic [7:0]  wr_data = 8'h00;
    logic [15:0] instr_addr;
    logic        instr_last;

    int checks = 0;
    int errors = 0;
    logic [15:0] m_pc = 16'h0000;
    logic [7:0]  m_page = 8'h00;

    always #10 clk = ~clk;

    jump_pc #(.DATA_W(8), .STEPS(2), .PAGE_DEST(PAGE_D), .OFFS_DEST(OFFS_D)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_dest    (wr_dest),
        .wr_data    (wr_data),
        .instr_addr (instr_addr),
        .instr_last (instr_last)
    );

    task automatic chk(input bit ok, input string req, input logic [15:0] act,
                       input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One instruction, entered at the falling edge of its first cycle.
    // 'early' puts the write in the first cycle instead of the last.
    task automatic instr(input bit wr, input bit early, input logic [7:0] dest,
                         input logic [7:0] data);
        chk(instr_last == 1'b0, "R2", 16'(instr_last), 16'h0);
        chk(instr_addr == m_pc, "R8", instr_addr, m_pc);
        wr_en = wr && early; wr_dest = dest; wr_data = data;
        @(negedge clk);
        chk(instr_last == 1'b1, "R2", 16'(instr_last), 16'h1);
        chk(instr_addr == m_pc, "R8", instr_addr, m_pc);
        wr_en = wr && !early;
        @(negedge clk);
        wr_en = 1'b0;
        if (wr && !early && dest == OFFS_D)      m_pc = {m_page, data};
        else                                      m_pc = m_pc + 16'h1;
        if (wr && !early && dest == PAGE_D)      m_page = data;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        chk(instr_addr == 16'h0, "R1", instr_addr, 16'h0);
        chk(instr_last == 1'b0, "R1", 16'(instr_last), 16'h0);
        rst_n = 1'b1;
        m_pc = 16'h0;
        m_page = 8'h0;
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();   // R1 reset state

        // R3: plain increments from zero
        for (int i = 0; i < 10; i++) begin
            instr(1'b0, 1'b0, 8'h00, 8'h00);
            chk(instr_addr == m_pc, "R3", instr_addr, m_pc);
        end

        // R4: page write does not jump, address still steps
        instr(1'b1, 1'b0, PAGE_D, 8'hAB);
        chk(instr_addr == 16'd11, "R4", instr_addr, 16'd11);
        // R5: offset write jumps to {page, offset}
        instr(1'b1, 1'b0, OFFS_D, 8'h34);
        chk(instr_addr == 16'hAB34, "R5", instr_addr, 16'hAB34);
        // R6: second jump in the same page needs only the offset
        instr(1'b0, 1'b0, 8'h00, 8'h00);
        instr(1'b1, 1'b0, OFFS_D, 8'h80);
        chk(instr_addr == 16'hAB80, "R6", instr_addr, 16'hAB80);

        // R3: wrap from the top of the address space
        instr(1'b1, 1'b0, PAGE_D, 8'hFF);
        instr(1'b1, 1'b0, OFFS_D, 8'hFF);
        chk(instr_addr == 16'hFFFF, "R5", instr_addr, 16'hFFFF);
        instr(1'b0, 1'b0, 8'h00, 8'h00);
        chk(instr_addr == 16'h0000, "R3", instr_addr, 16'h0000);

        // R5: every page with a varying offset
        for (int p = 0; p < 256; p++) begin
            instr(1'b1, 1'b0, PAGE_D, 8'(p));
            instr(1'b1, 1'b0, OFFS_D, ~8'(p));
            chk(instr_addr == {8'(p), ~8'(p)}, "R5", instr_addr, {8'(p), ~8'(p)});
        end

        // R7: every other destination leaves address stepping and page intact
        instr(1'b1, 1'b0, PAGE_D, 8'h3C);
        for (int d = 0; d < 256; d++) begin
            if (8'(d) != PAGE_D && 8'(d) != OFFS_D) begin
                instr(1'b1, 1'b0, 8'(d), 8'h5A);
                chk(instr_addr == m_pc, "R7", instr_addr, m_pc);
            end
        end
        instr(1'b1, 1'b0, OFFS_D, 8'h00);
        chk(instr_addr == 16'h3C00, "R7", instr_addr, 16'h3C00);

        // R7: writes in the first cycle are ignored
        instr(1'b1, 1'b1, OFFS_D, 8'h99);
        chk(instr_addr == 16'h3C01, "R7", instr_addr, 16'h3C01);
        instr(1'b1, 1'b1, PAGE_D, 8'h11);
        instr(1'b1, 1'b0, OFFS_D, 8'h22);
        chk(instr_addr == 16'h3C22, "R7", instr_addr, 16'h3C22);
        // R7: wr_en low on the offset destination is ignored
        instr(1'b0, 1'b0, OFFS_D, 8'h77);
        chk(instr_addr == 16'h3C23, "R7", instr_addr, 16'h3C23);

        // R1: reset in mid-run clears the held page too
        do_reset();
        instr(1'b1, 1'b0, OFFS_D, 8'h77);
        chk(instr_addr == 16'h0077, "R1", instr_addr, 16'h0077);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule